// File: doc/BRIEF.md
# Programmable Serial-Channel Interrupt Prioritizer

This block collects pending interrupt requests from four serial channels and ranks them in an order that software sets. It then raises one combined request toward a processor core. The ranking uses four priority slots, a (highest) to d (lowest). Each slot holds a two-bit selector that names the channel it stands for. The selectors can be rewritten while the block runs, and the new order takes effect on the next cycle.

A three-bit level field serves two purposes. It is the priority at which the combined request is presented, and a value of zero turns off every interrupt from the block. The core sees the level, plus the identifier of the winning channel. When the core raises the acknowledge input, the block captures the current winner and holds it until the next acknowledge.

Top module: `chan_irq_prioritizer`

## Requirements
- R1: After reset the level is 0 and the slots map identically: slot a picks channel 1 (identifier 0) through slot d picks channel 4 (identifier 3). The outputs `irq_lvl_o`, `win_valid_o`, `win_id_o`, `ack_valid_o` and `ack_id_o` are all 0.
- R2: A selector value k places channel k+1 in its slot, and `win_id_o` reports that channel as k. Slot a is `cfg_sel_i[1:0]`, slot b is `[3:2]`, slot c is `[5:4]` and slot d is `[7:6]`.
- R3: The winner is the channel mapped to the highest-ranked slot (a, then b, c, d) whose channel has a pending request. The outputs follow the inputs within the same cycle.
- R4: A selector write with `cfg_sel_we_i` high takes effect on the next cycle. No reset is needed.
- R5: While the level is 0, `irq_lvl_o` is 0 and `win_valid_o` is 0 whatever the requests are. Whenever `win_valid_o` is 0, `win_id_o` is 0.
- R6: When the level is nonzero and some mapped channel is pending, `irq_lvl_o` equals the level written through `cfg_lvl_we_i`. Level 7 is passed through unchanged. Otherwise `irq_lvl_o` is 0.
- R7: A channel mapped to several slots is resolved at its highest-ranked slot. A channel mapped to no slot never wins, and its request alone raises no level.
- R8: On a clock edge with `ack_i` high, `ack_id_o` and `ack_valid_o` take the winner and valid flag that were presented just before that edge. This holds even if requests or the mapping change at the same edge. Without `ack_i` they hold their values.
- R9: An acknowledge taken while no winner exists captures `ack_valid_o` = 0 and `ack_id_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 4 | Pending request per channel; bit i is channel i+1 |
| cfg_sel_we_i | input | 1 | Write strobe for the slot selectors |
| cfg_sel_i | input | 8 | Four packed two-bit slot selectors, slot a lowest |
| cfg_lvl_we_i | input | 1 | Write strobe for the level field |
| cfg_lvl_i | input | 3 | Level to write |
| irq_lvl_o | output | 3 | Combined request level, 0 when none |
| win_valid_o | output | 1 | A winner is presented |
| win_id_o | output | 2 | Identifier of the current winner |
| ack_i | input | 1 | Acknowledge; captures the current winner |
| ack_valid_o | output | 1 | Captured valid flag |
| ack_id_o | output | 2 | Captured winner identifier |

## Verification
Two things can land on the same clock edge: an acknowledge capture and a selector rewrite, often with the requests changing at that moment as well. The bench drives directed cycles that put `ack_i`, a new mapping and a new request pattern on one edge. It then expects the captured identifier to come from the old mapping and the pre-edge requests, while the next cycle's live winner follows the new mapping. Random stimulus then mixes acknowledges, mapping writes (including duplicate mappings) and level writes. Every cycle is compared against a slot-walk model held in the bench.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;
   // Level value that disables every request from the block
   localparam int unsigned LVL_OFF = 0;

   // Reset selector for a slot: identity order, wrapped to the channel count
   function automatic int unsigned slot_reset_sel(input int unsigned slot,
                                                  input int unsigned n_chan);
      return slot % n_chan;
   endfunction
endpackage

// File: rtl/chan_irq_cfg.sv
module chan_irq_cfg #(
   parameter int unsigned N_SLOT = 4,
   parameter int unsigned SEL_W  = 2,
   parameter int unsigned LVL_W  = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sel_we,
   input  logic [N_SLOT*SEL_W-1:0] sel_wdata,
   input  logic                    lvl_we,
   input  logic [LVL_W-1:0]        lvl_wdata,
   output logic [N_SLOT*SEL_W-1:0] sel_q,
   output logic [LVL_W-1:0]        lvl_q
);
   import chan_irq_pkg::*;
   localparam int unsigned N_CHAN = 1 << SEL_W;

   for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sel_q[s*SEL_W +: SEL_W] <= SEL_W'(slot_reset_sel(s, N_CHAN));
         else if (sel_we)
            sel_q[s*SEL_W +: SEL_W] <= sel_wdata[s*SEL_W +: SEL_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lvl_q <= LVL_W'(LVL_OFF);
      else if (lvl_we)
         lvl_q <= lvl_wdata;
   end
endmodule

// File: rtl/chan_irq_arb.sv
module chan_irq_arb #(
   parameter int unsigned N_CHAN = 4,
   parameter int unsigned N_SLOT = 4,
   parameter int unsigned SEL_W  = 2,
   parameter int unsigned LVL_W  = 3
) (
   input  logic [N_CHAN-1:0]       req,
   input  logic [N_SLOT*SEL_W-1:0] sel,
   input  logic [LVL_W-1:0]        lvl,
   output logic                    win_valid,
   output logic [SEL_W-1:0]        win_id,
   output logic [LVL_W-1:0]        irq_lvl
);
   import chan_irq_pkg::*;

   logic [N_SLOT-1:0] slot_hit;
   logic              found;
   logic [SEL_W-1:0]  found_id;
   logic              enabled;

   // Each slot raises the request of the channel it names
   for (genvar s = 0; s < N_SLOT; s++) begin : g_hit
      assign slot_hit[s] = req[sel[s*SEL_W +: SEL_W]];
   end

   // Walk from slot a down; the first hit wins
   always_comb begin
      found    = 1'b0;
      found_id = '0;
      for (int s = 0; s < N_SLOT; s++) begin
         if (!found && slot_hit[s]) begin
            found    = 1'b1;
            found_id = sel[s*SEL_W +: SEL_W];
         end
      end
   end

   assign enabled   = (lvl != LVL_W'(LVL_OFF));
   assign win_valid = found && enabled;
   assign win_id    = win_valid ? found_id : '0;
   assign irq_lvl   = win_valid ? lvl : '0;
endmodule

// File: rtl/chan_irq_ack.sv
module chan_irq_ack #(
   parameter int unsigned SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ack,
   input  logic             win_valid,
   input  logic [SEL_W-1:0] win_id,
   output logic             cap_valid,
   output logic [SEL_W-1:0] cap_id
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_valid <= 1'b0;
         cap_id    <= '0;
      end else if (ack) begin
         cap_valid <= win_valid;
         cap_id    <= win_id;
      end
   end
endmodule

// File: rtl/chan_irq_prioritizer.sv
module chan_irq_prioritizer #(
   parameter int unsigned N_CHAN = 4,
   parameter int unsigned N_SLOT = 4,
   parameter int unsigned LVL_W  = 3,
   localparam int unsigned SEL_W = $clog2(N_CHAN),
   localparam int unsigned CFG_W = N_SLOT * SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_CHAN-1:0] req_i,
   input  logic              cfg_sel_we_i,
   input  logic [CFG_W-1:0]  cfg_sel_i,
   input  logic              cfg_lvl_we_i,
   input  logic [LVL_W-1:0]  cfg_lvl_i,
   output logic [LVL_W-1:0]  irq_lvl_o,
   output logic              win_valid_o,
   output logic [SEL_W-1:0]  win_id_o,
   input  logic              ack_i,
   output logic              ack_valid_o,
   output logic [SEL_W-1:0]  ack_id_o
);
   // Elaboration-time parameter checks
   if (N_CHAN < 2 || (1 << SEL_W) != N_CHAN) begin : g_bad_chan
      $error("N_CHAN must be a power of two of at least 2");
   end
   if (N_SLOT < 1) begin : g_bad_slot
      $error("N_SLOT must be at least 1");
   end
   if (LVL_W < 1) begin : g_bad_lvl
      $error("LVL_W must be at least 1");
   end

   logic [CFG_W-1:0] sel_q;
   logic [LVL_W-1:0] lvl_q;

   chan_irq_cfg #(.N_SLOT(N_SLOT), .SEL_W(SEL_W), .LVL_W(LVL_W)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_we    (cfg_sel_we_i),
      .sel_wdata (cfg_sel_i),
      .lvl_we    (cfg_lvl_we_i),
      .lvl_wdata (cfg_lvl_i),
      .sel_q     (sel_q),
      .lvl_q     (lvl_q)
   );

   chan_irq_arb #(.N_CHAN(N_CHAN), .N_SLOT(N_SLOT), .SEL_W(SEL_W), .LVL_W(LVL_W)) u_arb (
      .req       (req_i),
      .sel       (sel_q),
      .lvl       (lvl_q),
      .win_valid (win_valid_o),
      .win_id    (win_id_o),
      .irq_lvl   (irq_lvl_o)
   );

   chan_irq_ack #(.SEL_W(SEL_W)) u_ack (
      .clk       (clk),
      .rst_n     (rst_n),
      .ack       (ack_i),
      .win_valid (win_valid_o),
      .win_id    (win_id_o),
      .cap_valid (ack_valid_o),
      .cap_id    (ack_id_o)
   );
endmodule

// File: rtl/chan_irq_prioritizer_chk.sv
module chan_irq_prioritizer_chk #(
   parameter int unsigned N_CHAN = 4,
   parameter int unsigned LVL_W  = 3,
   parameter int unsigned SEL_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_CHAN-1:0] req_i,
   input logic              cfg_lvl_we_i,
   input logic [LVL_W-1:0]  cfg_lvl_i,
   input logic [LVL_W-1:0]  irq_lvl_o,
   input logic              win_valid_o,
   input logic [SEL_W-1:0]  win_id_o,
   input logic              ack_i,
   input logic              ack_valid_o,
   input logic [SEL_W-1:0]  ack_id_o
);
   // R3: a presented winner always has its request pending
   p_winner_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid_o |-> req_i[win_id_o]);

   // R5: no winner means a zero level and a zero identifier
   p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !win_valid_o |-> (irq_lvl_o == '0 && win_id_o == '0));

   // R6: a level written while a winner exists is presented next cycle
   p_level_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_lvl_we_i |=> (!win_valid_o || irq_lvl_o == $past(cfg_lvl_i)));

   // R8: acknowledge captures the pre-edge winner
   p_ack_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ack_i |=> (ack_id_o == $past(win_id_o) && ack_valid_o == $past(win_valid_o)));

   // R8: captured values hold without acknowledge
   p_ack_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_i |=> ($stable(ack_id_o) && $stable(ack_valid_o)));
endmodule

bind chan_irq_prioritizer chan_irq_prioritizer_chk #(
   .N_CHAN(N_CHAN), .LVL_W(LVL_W), .SEL_W(SEL_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_i        (req_i),
   .cfg_lvl_we_i (cfg_lvl_we_i),
   .cfg_lvl_i    (cfg_lvl_i),
   .irq_lvl_o    (irq_lvl_o),
   .win_valid_o  (win_valid_o),
   .win_id_o     (win_id_o),
   .ack_i        (ack_i),
   .ack_valid_o  (ack_valid_o),
   .ack_id_o     (ack_id_o)
);

// File: tb/chan_irq_prioritizer_tb.sv
module chan_irq_prioritizer_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] req_i = '0;
   logic       cfg_sel_we_i = 1'b0;
   logic [7:0] cfg_sel_i = '0;
   logic       cfg_lvl_we_i = 1'b0;
   logic [2:0] cfg_lvl_i = '0;
   logic [2:0] irq_lvl_o;
   logic       win_valid_o;
   logic [1:0] win_id_o;
   logic       ack_i = 1'b0;
   logic       ack_valid_o;
   logic [1:0] ack_id_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench model state
   int m_sel[4] = '{0, 1, 2, 3};
   int m_lvl = 0;
   int e_ack_v = 0;
   int e_ack_id = 0;

   always #10 clk = ~clk;   // 50 MHz

   chan_irq_prioritizer u_dut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i),
      .cfg_sel_we_i(cfg_sel_we_i), .cfg_sel_i(cfg_sel_i),
      .cfg_lvl_we_i(cfg_lvl_we_i), .cfg_lvl_i(cfg_lvl_i),
      .irq_lvl_o(irq_lvl_o), .win_valid_o(win_valid_o), .win_id_o(win_id_o),
      .ack_i(ack_i), .ack_valid_o(ack_valid_o), .ack_id_o(ack_id_o)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // winner by slot walk; -1 when nothing wins
   function automatic int exp_win(input logic [3:0] r);
      if (m_lvl == 0) return -1;
      for (int s = 0; s < 4; s++)
         if (r[m_sel[s]]) return m_sel[s];
      return -1;
   endfunction

   function automatic logic [7:0] pack(input int a, input int b, input int c, input int d);
      return {2'(d), 2'(c), 2'(b), 2'(a)};
   endfunction

   // one cycle: check capture, drive, check live outputs, apply edge to model
   task automatic cyc(input logic [3:0] r, input bit swe, input logic [7:0] sv,
                      input bit lwe, input logic [2:0] lv, input bit ak, input string tag);
      int w;
      @(negedge clk);
      check(ak ? tag : "R8", "ack_valid_o", int'(ack_valid_o), e_ack_v);
      check(ak ? tag : "R8", "ack_id_o", int'(ack_id_o), e_ack_id);
      req_i = r; cfg_sel_we_i = swe; cfg_sel_i = sv;
      cfg_lvl_we_i = lwe; cfg_lvl_i = lv; ack_i = ak;
      #5;
      w = exp_win(r);
      check(tag, "win_valid_o", int'(win_valid_o), (w >= 0) ? 1 : 0);
      check(tag, "win_id_o", int'(win_id_o), (w >= 0) ? w : 0);
      check(tag, "irq_lvl_o", int'(irq_lvl_o), (w >= 0) ? m_lvl : 0);
      @(posedge clk);
      if (ak) begin
         e_ack_v = (w >= 0) ? 1 : 0;
         e_ack_id = (w >= 0) ? w : 0;
      end
      if (swe) for (int s = 0; s < 4; s++) m_sel[s] = int'(sv[s*2 +: 2]);
      if (lwe) m_lvl = int'(lv);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4321));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      req_i = 4'hF;
      #5;
      // R1: reset state, level 0 masks even with all pending
      check("R1", "irq_lvl_o", int'(irq_lvl_o), 0);
      check("R1", "win_valid_o", int'(win_valid_o), 0);
      check("R1", "ack_valid_o", int'(ack_valid_o), 0);
      check("R1", "ack_id_o", int'(ack_id_o), 0);

      // R1: set only the level, identity mapping must be in place
      cyc(4'h0, 0, 8'h00, 1, 3'd4, 0, "R1");
      cyc(4'hF, 0, 8'h00, 0, 3'd0, 0, "R1");
      cyc(4'hC, 0, 8'h00, 0, 3'd0, 0, "R1");
      cyc(4'h8, 0, 8'h00, 0, 3'd0, 0, "R2");
      // R3: rank order under identity
      cyc(4'h6, 0, 8'h00, 0, 3'd0, 0, "R3");
      cyc(4'h0, 0, 8'h00, 0, 3'd0, 0, "R3");
      // R4/R2: reverse mapping takes effect next cycle
      cyc(4'hF, 1, pack(3, 2, 1, 0), 0, 3'd0, 0, "R4");
      cyc(4'hF, 0, 8'h00, 0, 3'd0, 0, "R4");
      cyc(4'h3, 0, 8'h00, 0, 3'd0, 0, "R2");
      // R6: level 7 passed through
      cyc(4'h1, 0, 8'h00, 1, 3'd7, 0, "R6");
      cyc(4'h1, 0, 8'h00, 0, 3'd0, 0, "R6");
      // R7: every slot names channel 2; others pending never win
      cyc(4'hD, 1, pack(1, 1, 1, 1), 0, 3'd0, 0, "R7");
      cyc(4'hD, 0, 8'h00, 0, 3'd0, 0, "R7");
      cyc(4'h2, 0, 8'h00, 0, 3'd0, 0, "R7");
      // R7: duplicate resolved at highest slot
      cyc(4'h5, 1, pack(2, 0, 2, 3), 0, 3'd0, 0, "R7");
      cyc(4'h5, 0, 8'h00, 0, 3'd0, 0, "R7");
      cyc(4'hA, 0, 8'h00, 0, 3'd0, 0, "R7");
      // R8: ack together with remap and request change
      cyc(4'h9, 1, pack(0, 1, 2, 3), 0, 3'd0, 1, "R8");
      cyc(4'h6, 0, 8'h00, 0, 3'd0, 0, "R8");
      cyc(4'h4, 0, 8'h00, 0, 3'd0, 1, "R8");
      cyc(4'h1, 0, 8'h00, 0, 3'd0, 0, "R8");
      // R5 and R9: level 0 masks; ack then captures no winner
      cyc(4'hF, 0, 8'h00, 1, 3'd0, 0, "R5");
      cyc(4'hF, 0, 8'h00, 0, 3'd0, 1, "R9");
      cyc(4'hF, 0, 8'h00, 1, 3'd3, 0, "R9");
      cyc(4'h0, 0, 8'h00, 0, 3'd0, 1, "R9");
      cyc(4'h2, 0, 8'h00, 0, 3'd0, 0, "R9");

      // random mix
      for (int i = 0; i < 3000; i++) begin
         cyc(4'($urandom), ($urandom % 8) == 0, 8'($urandom),
             ($urandom % 10) == 0, 3'($urandom), ($urandom % 4) == 0, "R3");
      end
      cyc(4'h0, 0, 8'h00, 0, 3'd0, 0, "R6");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule